// File: doc/BRIEF.md
# Dual-Issue Warp Instruction Scheduler

This block sits between the per-warp instruction buffers and the execution units of a SIMT core. A fixed pool of warp slots holds, for each resident warp, its next two decoded instructions and its lane mask. In every clock cycle the block chooses one warp and issues one or two instructions from it. A warp can be chosen only if its head instruction is present, the unit class that instruction needs is free, and none of the registers it names is waiting on a result. The warps in the pool can come from any mix of kernels or thread blocks, and they are interleaved cycle by cycle.

A second instruction from the same warp goes out in the same cycle only when three things hold: it has no data dependency on the first, it targets a different unit class, and that unit is free. Two integer/single-precision ALU operations are never paired. A per-warp register scoreboard marks each issued destination as pending. The mark clears when the execution side reports writeback. The issue decision is combinational from the slot contents and the registered state. A per-slot pop pulse tells the front end how many instructions were taken at the clock edge.

Top module: `warp_sched_dual`

## Requirements
- R1: At most one warp issues per cycle. Issue port 1 is valid only together with port 0, and it carries the same warp ID.
- R2: A warp is eligible only if all of the following hold: its head instruction is valid, the busy input for the head's unit class is low, and the scoreboard bits for the head's source A, source B and destination are all clear. A slot whose head is empty never issues, even when its second instruction is valid.
- R3: Among the eligible warps, the winner is the first one found searching upward from the warp that last issued, wrapping from the top index to 0.
- R4: The second instruction is paired only under all of these conditions: it is valid, its class differs from the head's class, its unit is not busy, and its own three registers are clear in the scoreboard. Otherwise only the head issues.
- R5: No pair is formed when the second instruction reads the head's destination, or writes the head's destination. A pair is still formed when the second instruction reads the head's sources or overwrites one of them.
- R6: Two instructions of class ALU are never issued together. Class codes: ALU=0, LSU=1, SFU=2, DPU=3, TEX=4.
- R7: Each issue port carries the warp's 32-bit lane mask unchanged. A warp whose mask is all zero still issues. Each port also carries the opcode word and the destination of its instruction.
- R8: Each issued destination register sets that warp's scoreboard bit at the clock edge. A writeback release for (warp, register) clears only that bit at the next edge, so the waiting instruction can issue in the cycle after the release is presented.
- R9: pop_one of the winning slot is high on single issue, and pop_two is high on dual issue. Across both vectors at most one bit is high.
- R10: A warp that stays eligible issues within 16 cycles.
- R11: After reset the scoreboard is clear, and warp 0 has top priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| head_vld | input | 16 | Head instruction present, per slot |
| head_cls | input | 16*3 | Head unit class, per slot |
| head_src_a | input | 16*5 | Head first source register |
| head_src_b | input | 16*5 | Head second source register |
| head_dst | input | 16*5 | Head destination register |
| head_op | input | 16*16 | Head opcode word (opaque) |
| next_vld | input | 16 | Second instruction present, per slot |
| next_cls | input | 16*3 | Second instruction unit class |
| next_src_a | input | 16*5 | Second instruction first source |
| next_src_b | input | 16*5 | Second instruction second source |
| next_dst | input | 16*5 | Second instruction destination |
| next_op | input | 16*16 | Second instruction opcode word |
| lane_mask | input | 16*32 | Active-lane mask per slot |
| unit_busy | input | 5 | Busy flag per unit class |
| wb_vld | input | 1 | Writeback release strobe |
| wb_warp | input | 4 | Warp of released register |
| wb_reg | input | 5 | Released register |
| iss0_vld | output | 1 | Port 0 issues |
| iss0_warp | output | 4 | Port 0 warp ID |
| iss0_cls | output | 3 | Port 0 unit class |
| iss0_op | output | 16 | Port 0 opcode word |
| iss0_dst | output | 5 | Port 0 destination |
| iss0_mask | output | 32 | Port 0 lane mask |
| iss1_vld | output | 1 | Port 1 issues |
| iss1_warp | output | 4 | Port 1 warp ID |
| iss1_cls | output | 3 | Port 1 unit class |
| iss1_op | output | 16 | Port 1 opcode word |
| iss1_dst | output | 5 | Port 1 destination |
| iss1_mask | output | 32 | Port 1 lane mask |
| pop_one | output | 16 | Slot gave one instruction |
| pop_two | output | 16 | Slot gave two instructions |

## Verification
The block holds two pieces of state, the scoreboard and the round-robin pointer. A wrong scoreboard bit shows at the ports in the next cycle in one of two ways. A stuck-set bit leaves a warp silent after its release. A lost bit lets a dependent instruction issue while its producer is still in flight. A corrupted pointer shows within one cycle as the wrong winner when two warps compete, and over a full sweep of 16 warps as a broken ascending order. The pairing rules are purely combinational, so every class, busy and dependency combination is visible in the same cycle on iss1_vld and on the pop vectors.

// File: rtl/wsd_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the dual-issue warp scheduler.
// Assumes three bits are enough to encode every execution-unit class.
package wsd_pkg;
    localparam int CLS_W   = 3;
    localparam int NUM_CLS = 5;

    typedef enum logic [CLS_W-1:0] {
        UC_ALU = 3'd0,
        UC_LSU = 3'd1,
        UC_SFU = 3'd2,
        UC_DPU = 3'd3,
        UC_TEX = 3'd4
    } unit_cls_e;

    // True when two classes may share one issue cycle
    function automatic logic cls_pairable(input logic [CLS_W-1:0] a, input logic [CLS_W-1:0] b);
        return (a != b) && !((a == UC_ALU) && (b == UC_ALU));
    endfunction
endpackage

// File: rtl/wsd_warp_qual.sv
`timescale 1ns/1ps
// Per-warp qualifier: decides whether a slot's head instruction may issue
// and whether its second instruction may ride along in the same cycle.
// Assumes the scoreboard row and busy flags are stable within the cycle.
module wsd_warp_qual import wsd_pkg::*; #(
    parameter int NUM_REGS = 32,
    localparam int REG_W = $clog2(NUM_REGS)
) (
    input  logic                head_vld,
    input  logic [CLS_W-1:0]    head_cls,
    input  logic [REG_W-1:0]    head_src_a,
    input  logic [REG_W-1:0]    head_src_b,
    input  logic [REG_W-1:0]    head_dst,
    input  logic                next_vld,
    input  logic [CLS_W-1:0]    next_cls,
    input  logic [REG_W-1:0]    next_src_a,
    input  logic [REG_W-1:0]    next_src_b,
    input  logic [REG_W-1:0]    next_dst,
    input  logic [NUM_REGS-1:0] sb_row,
    input  logic [NUM_CLS-1:0]  unit_busy,
    output logic                eligible,
    output logic                pair_ok
);
    localparam int PAD_W = 2**CLS_W;

    logic [PAD_W-1:0] busy_pad;
    logic head_hazard;
    logic next_hazard;
    logic intra_dep;

    // Widen busy flags so any class code indexes safely
    assign busy_pad = {{(PAD_W-NUM_CLS){1'b0}}, unit_busy};

    // Scoreboard lookups for both instructions
    always_comb begin
        head_hazard = sb_row[head_src_a] | sb_row[head_src_b] | sb_row[head_dst];
        next_hazard = sb_row[next_src_a] | sb_row[next_src_b] | sb_row[next_dst];
    end

    // Read-after-write or write-after-write on the head's destination
    assign intra_dep = (next_src_a == head_dst) || (next_src_b == head_dst) ||
                       (next_dst == head_dst);

    // Head eligibility
    assign eligible = head_vld && !busy_pad[head_cls] && !head_hazard;

    // Companion eligibility
    assign pair_ok = eligible && next_vld && !busy_pad[next_cls] && !next_hazard &&
                     !intra_dep && cls_pairable(head_cls, next_cls);
endmodule

// File: rtl/wsd_rr_pick.sv
`timescale 1ns/1ps
// Rotating-priority picker: grants the first requester above the last winner.
// Assumes requests are combinational and may change every cycle.
module wsd_rr_pick #(
    parameter int N = 16,
    localparam int IDX_W = $clog2(N),
    localparam int CNT_W = $clog2(N+1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     req,
    output logic             gnt_vld,
    output logic [IDX_W-1:0] gnt_idx
);
    logic [IDX_W-1:0] last_q;

    // Circular search starting just above the last winner
    always_comb begin
        gnt_vld = 1'b0;
        gnt_idx = '0;
        for (int k = 1; k <= N; k++) begin
            logic [IDX_W-1:0] cand;
            cand = IDX_W'((int'(last_q) + k) % N);
            if (!gnt_vld && req[cand]) begin
                gnt_vld = 1'b1;
                gnt_idx = cand;
            end
        end
    end

    // Remember the last winner; reset gives index 0 top priority
    always_ff @(posedge clk) begin
        if (!rst_n)
            last_q <= IDX_W'(N-1);
        else if (gnt_vld)
            last_q <= gnt_idx;
    end

    // Starvation watch: cycles a requester has waited without a grant
    for (genvar w = 0; w < N; w++) begin : g_wait
        logic [CNT_W-1:0] wait_q;

        // Count consecutive unserved request cycles
        always_ff @(posedge clk) begin
            if (!rst_n)
                wait_q <= '0;
            else if (req[w] && !(gnt_vld && gnt_idx == IDX_W'(w)))
                wait_q <= wait_q + 1'b1;
            else
                wait_q <= '0;
        end

        // R10
        starve_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
            wait_q < CNT_W'(N));
    end

    // R1
    single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_vld |-> req[gnt_idx]);
endmodule

// File: rtl/wsd_scoreboard.sv
`timescale 1ns/1ps
// Per-warp pending-register bits: set on issue, cleared by writeback release.
// Assumes at most two sets and one clear per cycle; a set beats a clear.
module wsd_scoreboard #(
    parameter int N = 16,
    parameter int NUM_REGS = 32,
    localparam int IDX_W = $clog2(N),
    localparam int REG_W = $clog2(NUM_REGS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  set0_en,
    input  logic [IDX_W-1:0]      set0_warp,
    input  logic [REG_W-1:0]      set0_reg,
    input  logic                  set1_en,
    input  logic [IDX_W-1:0]      set1_warp,
    input  logic [REG_W-1:0]      set1_reg,
    input  logic                  clr_en,
    input  logic [IDX_W-1:0]      clr_warp,
    input  logic [REG_W-1:0]      clr_reg,
    output logic [N*NUM_REGS-1:0] sb_flat
);
    for (genvar w = 0; w < N; w++) begin : g_row
        logic [NUM_REGS-1:0] row_q;
        logic [NUM_REGS-1:0] row_d;

        // Next row value: release first, then issue marks on top
        always_comb begin
            row_d = row_q;
            if (clr_en && clr_warp == IDX_W'(w))
                row_d[clr_reg] = 1'b0;
            if (set0_en && set0_warp == IDX_W'(w))
                row_d[set0_reg] = 1'b1;
            if (set1_en && set1_warp == IDX_W'(w))
                row_d[set1_reg] = 1'b1;
        end

        // Row storage
        always_ff @(posedge clk) begin
            if (!rst_n)
                row_q <= '0;
            else
                row_q <= row_d;
        end

        assign sb_flat[w*NUM_REGS +: NUM_REGS] = row_q;
    end

    int unsigned pos0;
    int unsigned pos1;
    int unsigned posc;
    logic clr_alone;

    assign pos0 = int'(set0_warp) * NUM_REGS + int'(set0_reg);
    assign pos1 = int'(set1_warp) * NUM_REGS + int'(set1_reg);
    assign posc = int'(clr_warp) * NUM_REGS + int'(clr_reg);
    assign clr_alone = clr_en && !(set0_en && pos0 == posc) && !(set1_en && pos1 == posc);

    // R8
    issue_free_dst0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set0_en |-> !sb_flat[pos0]);
    // R8
    issue_free_dst1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set1_en |-> !sb_flat[pos1]);
    // R8
    issue_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set0_en |=> sb_flat[$past(pos0)]);
    // R8
    release_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_alone |=> !sb_flat[$past(posc)]);
endmodule

// File: rtl/warp_sched_dual.sv
`timescale 1ns/1ps
// Dual-issue warp scheduler top. Each cycle picks one eligible warp by
// rotating priority and issues its head, plus its second instruction when
// the pairing rules allow. Issue and pop outputs are combinational; the
// front end must consume popped instructions at the clock edge.
module warp_sched_dual import wsd_pkg::*; #(
    parameter int NUM_WARPS = 16,
    parameter int NUM_REGS  = 32,
    parameter int LANES     = 32,
    parameter int OP_W      = 16,
    localparam int WID_W = $clog2(NUM_WARPS),
    localparam int REG_W = $clog2(NUM_REGS)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_WARPS-1:0]         head_vld,
    input  logic [NUM_WARPS*CLS_W-1:0]   head_cls,
    input  logic [NUM_WARPS*REG_W-1:0]   head_src_a,
    input  logic [NUM_WARPS*REG_W-1:0]   head_src_b,
    input  logic [NUM_WARPS*REG_W-1:0]   head_dst,
    input  logic [NUM_WARPS*OP_W-1:0]    head_op,
    input  logic [NUM_WARPS-1:0]         next_vld,
    input  logic [NUM_WARPS*CLS_W-1:0]   next_cls,
    input  logic [NUM_WARPS*REG_W-1:0]   next_src_a,
    input  logic [NUM_WARPS*REG_W-1:0]   next_src_b,
    input  logic [NUM_WARPS*REG_W-1:0]   next_dst,
    input  logic [NUM_WARPS*OP_W-1:0]    next_op,
    input  logic [NUM_WARPS*LANES-1:0]   lane_mask,
    input  logic [NUM_CLS-1:0]           unit_busy,
    input  logic                         wb_vld,
    input  logic [WID_W-1:0]             wb_warp,
    input  logic [REG_W-1:0]             wb_reg,
    output logic                         iss0_vld,
    output logic [WID_W-1:0]             iss0_warp,
    output logic [CLS_W-1:0]             iss0_cls,
    output logic [OP_W-1:0]              iss0_op,
    output logic [REG_W-1:0]             iss0_dst,
    output logic [LANES-1:0]             iss0_mask,
    output logic                         iss1_vld,
    output logic [WID_W-1:0]             iss1_warp,
    output logic [CLS_W-1:0]             iss1_cls,
    output logic [OP_W-1:0]              iss1_op,
    output logic [REG_W-1:0]             iss1_dst,
    output logic [LANES-1:0]             iss1_mask,
    output logic [NUM_WARPS-1:0]         pop_one,
    output logic [NUM_WARPS-1:0]         pop_two
);
    localparam int PAD_W = 2**CLS_W;

    logic [NUM_WARPS-1:0]          elig;
    logic [NUM_WARPS-1:0]          pair;
    logic [CLS_W-1:0]              h_cls [NUM_WARPS];
    logic [CLS_W-1:0]              n_cls [NUM_WARPS];
    logic [REG_W-1:0]              h_a   [NUM_WARPS];
    logic [REG_W-1:0]              h_b   [NUM_WARPS];
    logic [REG_W-1:0]              h_d   [NUM_WARPS];
    logic [REG_W-1:0]              n_a   [NUM_WARPS];
    logic [REG_W-1:0]              n_b   [NUM_WARPS];
    logic [REG_W-1:0]              n_d   [NUM_WARPS];
    logic [OP_W-1:0]               h_op  [NUM_WARPS];
    logic [OP_W-1:0]               n_op  [NUM_WARPS];
    logic [LANES-1:0]              msk   [NUM_WARPS];
    logic [NUM_WARPS*NUM_REGS-1:0] sb_flat;
    logic                          gnt_vld;
    logic [WID_W-1:0]              gnt_idx;

    // Slot unpacking and per-warp qualification
    for (genvar w = 0; w < NUM_WARPS; w++) begin : g_slot
        assign h_cls[w] = head_cls[w*CLS_W +: CLS_W];
        assign n_cls[w] = next_cls[w*CLS_W +: CLS_W];
        assign h_a[w]   = head_src_a[w*REG_W +: REG_W];
        assign h_b[w]   = head_src_b[w*REG_W +: REG_W];
        assign h_d[w]   = head_dst[w*REG_W +: REG_W];
        assign n_a[w]   = next_src_a[w*REG_W +: REG_W];
        assign n_b[w]   = next_src_b[w*REG_W +: REG_W];
        assign n_d[w]   = next_dst[w*REG_W +: REG_W];
        assign h_op[w]  = head_op[w*OP_W +: OP_W];
        assign n_op[w]  = next_op[w*OP_W +: OP_W];
        assign msk[w]   = lane_mask[w*LANES +: LANES];

        wsd_warp_qual #(.NUM_REGS(NUM_REGS)) qual_i (
            .head_vld   (head_vld[w]),
            .head_cls   (h_cls[w]),
            .head_src_a (h_a[w]),
            .head_src_b (h_b[w]),
            .head_dst   (h_d[w]),
            .next_vld   (next_vld[w]),
            .next_cls   (n_cls[w]),
            .next_src_a (n_a[w]),
            .next_src_b (n_b[w]),
            .next_dst   (n_d[w]),
            .sb_row     (sb_flat[w*NUM_REGS +: NUM_REGS]),
            .unit_busy  (unit_busy),
            .eligible   (elig[w]),
            .pair_ok    (pair[w])
        );

        // Pop pulses for the front end
        assign pop_one[w] = gnt_vld && (gnt_idx == WID_W'(w)) && !pair[w];
        assign pop_two[w] = gnt_vld && (gnt_idx == WID_W'(w)) &&  pair[w];
    end

    wsd_rr_pick #(.N(NUM_WARPS)) pick_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (elig),
        .gnt_vld (gnt_vld),
        .gnt_idx (gnt_idx)
    );

    // Issue port 0 carries the winner's head
    always_comb begin
        iss0_vld  = gnt_vld;
        iss0_warp = gnt_idx;
        iss0_cls  = h_cls[gnt_idx];
        iss0_op   = h_op[gnt_idx];
        iss0_dst  = h_d[gnt_idx];
        iss0_mask = msk[gnt_idx];
    end

    // Issue port 1 carries the winner's companion when pairing holds
    always_comb begin
        iss1_vld  = gnt_vld && pair[gnt_idx];
        iss1_warp = gnt_idx;
        iss1_cls  = n_cls[gnt_idx];
        iss1_op   = n_op[gnt_idx];
        iss1_dst  = n_d[gnt_idx];
        iss1_mask = msk[gnt_idx];
    end

    wsd_scoreboard #(.N(NUM_WARPS), .NUM_REGS(NUM_REGS)) sb_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .set0_en   (iss0_vld),
        .set0_warp (iss0_warp),
        .set0_reg  (iss0_dst),
        .set1_en   (iss1_vld),
        .set1_warp (iss1_warp),
        .set1_reg  (iss1_dst),
        .clr_en    (wb_vld),
        .clr_warp  (wb_warp),
        .clr_reg   (wb_reg),
        .sb_flat   (sb_flat)
    );

    logic [PAD_W-1:0] busy_chk;
    assign busy_chk = {{(PAD_W-NUM_CLS){1'b0}}, unit_busy};

    // R1
    port1_needs_port0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iss1_vld |-> (iss0_vld && iss1_warp == iss0_warp));
    // R6
    no_alu_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iss1_vld |-> !(iss0_cls == UC_ALU && iss1_cls == UC_ALU));
    // R4
    pair_unit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iss1_vld |-> (iss1_cls != iss0_cls && !busy_chk[iss1_cls]));
    // R5
    pair_indep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iss1_vld |-> (n_a[gnt_idx] != iss0_dst && n_b[gnt_idx] != iss0_dst &&
                      iss1_dst != iss0_dst));
    // R2
    head_unit_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iss0_vld |-> (!busy_chk[iss0_cls] && head_vld[iss0_warp]));
    // R2
    head_src_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iss0_vld |-> (!sb_flat[int'(iss0_warp)*NUM_REGS + int'(h_a[gnt_idx])] &&
                      !sb_flat[int'(iss0_warp)*NUM_REGS + int'(h_b[gnt_idx])]));
    // R9
    pop_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pop_one, pop_two}) && ((|{pop_one, pop_two}) == iss0_vld));
endmodule

// File: tb/warp_sched_dual_tb_top.sv
`timescale 1ns/1ps
// Bench: a vector table for pairing rules, then directed tests for reset,
// rotation order, scoreboard release, empty slots and lane masks.
module warp_sched_dual_tb_top;
    localparam int W = 16;
    localparam logic [2:0] C_ALU = 3'd0, C_LSU = 3'd1, C_SFU = 3'd2,
                           C_DPU = 3'd3, C_TEX = 3'd4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [W-1:0] hv, nv;
    logic [2:0]   hc [W];
    logic [2:0]   nc [W];
    logic [4:0]   ha [W], hb [W], hd [W], na [W], nb [W], nd [W];
    logic [15:0]  hop [W], nop [W];
    logic [31:0]  msk [W];
    logic [4:0]   busy;
    logic         wb_vld;
    logic [3:0]   wb_warp;
    logic [4:0]   wb_reg;

    logic [W*3-1:0]  f_hc, f_nc;
    logic [W*5-1:0]  f_ha, f_hb, f_hd, f_na, f_nb, f_nd;
    logic [W*16-1:0] f_hop, f_nop;
    logic [W*32-1:0] f_msk;

    // Pack bench slot arrays onto the flat ports
    always_comb begin
        for (int w = 0; w < W; w++) begin
            f_hc[w*3 +: 3]    = hc[w];
            f_nc[w*3 +: 3]    = nc[w];
            f_ha[w*5 +: 5]    = ha[w];
            f_hb[w*5 +: 5]    = hb[w];
            f_hd[w*5 +: 5]    = hd[w];
            f_na[w*5 +: 5]    = na[w];
            f_nb[w*5 +: 5]    = nb[w];
            f_nd[w*5 +: 5]    = nd[w];
            f_hop[w*16 +: 16] = hop[w];
            f_nop[w*16 +: 16] = nop[w];
            f_msk[w*32 +: 32] = msk[w];
        end
    end

    logic        iss0_vld, iss1_vld;
    logic [3:0]  iss0_warp, iss1_warp;
    logic [2:0]  iss0_cls, iss1_cls;
    logic [15:0] iss0_op, iss1_op;
    logic [4:0]  iss0_dst, iss1_dst;
    logic [31:0] iss0_mask, iss1_mask;
    logic [W-1:0] pop_one, pop_two;

    warp_sched_dual dut_i (
        .clk(clk), .rst_n(rst_n),
        .head_vld(hv), .head_cls(f_hc), .head_src_a(f_ha), .head_src_b(f_hb),
        .head_dst(f_hd), .head_op(f_hop),
        .next_vld(nv), .next_cls(f_nc), .next_src_a(f_na), .next_src_b(f_nb),
        .next_dst(f_nd), .next_op(f_nop),
        .lane_mask(f_msk), .unit_busy(busy),
        .wb_vld(wb_vld), .wb_warp(wb_warp), .wb_reg(wb_reg),
        .iss0_vld(iss0_vld), .iss0_warp(iss0_warp), .iss0_cls(iss0_cls),
        .iss0_op(iss0_op), .iss0_dst(iss0_dst), .iss0_mask(iss0_mask),
        .iss1_vld(iss1_vld), .iss1_warp(iss1_warp), .iss1_cls(iss1_cls),
        .iss1_op(iss1_op), .iss1_dst(iss1_dst), .iss1_mask(iss1_mask),
        .pop_one(pop_one), .pop_two(pop_two)
    );

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic clear_all();
        for (int w = 0; w < W; w++) begin
            hv[w] = 1'b0; nv[w] = 1'b0;
            hc[w] = C_ALU; nc[w] = C_ALU;
            ha[w] = 5'd0; hb[w] = 5'd0; hd[w] = 5'd0;
            na[w] = 5'd0; nb[w] = 5'd0; nd[w] = 5'd0;
            hop[w] = 16'h1000 + 16'(w); nop[w] = 16'h2000 + 16'(w);
            msk[w] = 32'hFFFF_FFFF;
        end
        busy = '0;
        wb_vld = 1'b0; wb_warp = '0; wb_reg = '0;
    endtask

    task automatic set_head(input int w, input logic [2:0] c, input logic [4:0] a,
                            input logic [4:0] b, input logic [4:0] d);
        hv[w] = 1'b1; hc[w] = c; ha[w] = a; hb[w] = b; hd[w] = d;
    endtask

    task automatic set_next(input int w, input logic v, input logic [2:0] c,
                            input logic [4:0] a, input logic [4:0] b, input logic [4:0] d);
        nv[w] = v; nc[w] = c; na[w] = a; nb[w] = b; nd[w] = d;
    endtask

    task automatic reset_dut();
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Pairing vectors for warp 5; head is always src 1, src 2, dst 3
    typedef struct packed {
        logic [2:0] c0;
        logic [2:0] c1;
        logic       v1;
        logic [4:0] a1;
        logic [4:0] b1;
        logic [4:0] d1;
        logic [4:0] bz;
        logic       e_iss;
        logic       e_dual;
        logic [3:0] rq;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VT [NV] = '{
        '{C_ALU, C_LSU, 1'b1, 5'd4, 5'd5, 5'd6, 5'b00000, 1'b1, 1'b1, 4'd4}, // R4 basic pair
        '{C_ALU, C_ALU, 1'b1, 5'd4, 5'd5, 5'd6, 5'b00000, 1'b1, 1'b0, 4'd6}, // R6 two ALU
        '{C_ALU, C_SFU, 1'b1, 5'd3, 5'd5, 5'd6, 5'b00000, 1'b1, 1'b0, 4'd5}, // R5 RAW
        '{C_ALU, C_DPU, 1'b1, 5'd4, 5'd5, 5'd3, 5'b00000, 1'b1, 1'b0, 4'd5}, // R5 WAW
        '{C_LSU, C_LSU, 1'b1, 5'd4, 5'd5, 5'd6, 5'b00000, 1'b1, 1'b0, 4'd4}, // R4 same class
        '{C_ALU, C_TEX, 1'b1, 5'd4, 5'd5, 5'd6, 5'b10000, 1'b1, 1'b0, 4'd4}, // R4 companion busy
        '{C_ALU, C_LSU, 1'b1, 5'd4, 5'd5, 5'd6, 5'b00001, 1'b0, 1'b0, 4'd2}, // R2 head busy
        '{C_ALU, C_LSU, 1'b0, 5'd4, 5'd5, 5'd6, 5'b00000, 1'b1, 1'b0, 4'd4}, // R4 no companion
        '{C_SFU, C_ALU, 1'b1, 5'd4, 5'd5, 5'd6, 5'b00000, 1'b1, 1'b1, 4'd4}, // R4 reversed order
        '{C_DPU, C_TEX, 1'b1, 5'd1, 5'd2, 5'd6, 5'b00000, 1'b1, 1'b1, 4'd5}, // R5 shared sources
        '{C_ALU, C_LSU, 1'b1, 5'd4, 5'd5, 5'd6, 5'b00010, 1'b1, 1'b0, 4'd4}, // R4 LSU busy
        '{C_ALU, C_SFU, 1'b1, 5'd4, 5'd5, 5'd2, 5'b00000, 1'b1, 1'b1, 4'd5}  // R5 WAR allowed
    };

    initial begin
        clear_all();
        reset_dut();

        // Table walk
        for (int i = 0; i < NV; i++) begin
            string tg;
            reset_dut();
            clear_all();
            set_head(5, VT[i].c0, 5'd1, 5'd2, 5'd3);
            set_next(5, VT[i].v1, VT[i].c1, VT[i].a1, VT[i].b1, VT[i].d1);
            busy = VT[i].bz;
            #8;
            tg = $sformatf("R%0d vec %0d", VT[i].rq, i);
            chk({tg, " iss0_vld"}, 64'(iss0_vld), 64'(VT[i].e_iss));
            chk({tg, " iss1_vld"}, 64'(iss1_vld), 64'(VT[i].e_dual));
            // R9 pop vectors
            chk({tg, " R9 pop_one"}, 64'(pop_one), (VT[i].e_iss && !VT[i].e_dual) ? 64'h20 : 64'h0);
            chk({tg, " R9 pop_two"}, 64'(pop_two), VT[i].e_dual ? 64'h20 : 64'h0);
            if (VT[i].e_dual) begin
                // R1 same warp on both ports
                chk({tg, " R1 iss1_warp"}, 64'(iss1_warp), 64'd5);
                chk({tg, " R6 iss1_cls"}, 64'(iss1_cls), 64'(VT[i].c1));
            end
            @(negedge clk);
        end
        busy = '0;

        // R11 reset priority and R3 full rotation with all warps eligible
        reset_dut();
        clear_all();
        for (int w = 0; w < W; w++) set_head(w, C_ALU, 5'd1, 5'd2, 5'd3);
        for (int i = 0; i < W; i++) begin
            #8;
            chk(i == 0 ? "R11 first winner" : (i == W-1 ? "R10 last warp served" : "R3 rotation"),
                {59'(0), iss0_vld, iss0_warp}, {59'(0), 1'b1, 4'(i)});
            @(negedge clk);
        end
        #8;
        chk("R8 all destinations pending", 64'(iss0_vld), 64'd0);
        @(negedge clk);
        // Release of a wrong register leaves warp 7 blocked
        wb_vld = 1'b1; wb_warp = 4'd7; wb_reg = 5'd5;
        @(negedge clk);
        wb_vld = 1'b0;
        #8;
        chk("R8 wrong register release", 64'(iss0_vld), 64'd0);
        @(negedge clk);
        wb_vld = 1'b1; wb_warp = 4'd7; wb_reg = 5'd3;
        #8;
        chk("R8 release not yet visible", 64'(iss0_vld), 64'd0);
        @(negedge clk);
        wb_vld = 1'b0;
        #8;
        chk("R8 released warp issues", {59'(0), iss0_vld, iss0_warp}, {59'(0), 1'b1, 4'd7});
        @(negedge clk);

        // R3 wrap: last winner 7, candidates 3 and 9
        hv[3] = 1'b0; hv[9] = 1'b0;
        wb_vld = 1'b1; wb_warp = 4'd3; wb_reg = 5'd3;
        @(negedge clk);
        wb_warp = 4'd9;
        @(negedge clk);
        wb_vld = 1'b0; hv[3] = 1'b1; hv[9] = 1'b1;
        #8;
        chk("R3 above last winner", {59'(0), iss0_vld, iss0_warp}, {59'(0), 1'b1, 4'd9});
        @(negedge clk);
        #8;
        chk("R3 wrap to lower index", {59'(0), iss0_vld, iss0_warp}, {59'(0), 1'b1, 4'd3});
        @(negedge clk);

        // R2 source hazards and empty head
        reset_dut();
        clear_all();
        set_head(1, C_ALU, 5'd1, 5'd2, 5'd3);
        #8;
        chk("R2 producer issues", 64'(iss0_vld), 64'd1);
        @(negedge clk);
        set_head(1, C_LSU, 5'd3, 5'd4, 5'd8);
        #8;
        chk("R2 source A pending", 64'(iss0_vld), 64'd0);
        @(negedge clk);
        set_head(1, C_LSU, 5'd4, 5'd3, 5'd8);
        #8;
        chk("R2 source B pending", 64'(iss0_vld), 64'd0);
        @(negedge clk);
        hv[1] = 1'b0;
        set_next(6, 1'b1, C_LSU, 5'd9, 5'd10, 5'd11);
        #8;
        chk("R2 empty head slot", 64'({iss0_vld, pop_one, pop_two}), 64'd0);
        @(negedge clk);

        // R7 masks and payload
        reset_dut();
        clear_all();
        set_head(2, C_ALU, 5'd1, 5'd2, 5'd3);
        msk[2] = 32'h0;
        #8;
        chk("R7 zero mask issues", {31'(0), iss0_vld, iss0_mask}, {31'(0), 1'b1, 32'h0});
        chk("R7 port0 payload", {iss0_op, 11'(0), iss0_dst}, {16'h1002, 11'(0), 5'd3});
        @(negedge clk);
        hv[2] = 1'b0;
        set_head(4, C_SFU, 5'd1, 5'd2, 5'd3);
        set_next(4, 1'b1, C_ALU, 5'd5, 5'd6, 5'd7);
        msk[4] = 32'hA5C3_0F01;
        #8;
        chk("R7 port0 mask", 64'(iss0_mask), 64'hA5C3_0F01);
        chk("R7 port1 mask", 64'(iss1_mask), 64'hA5C3_0F01);
        chk("R7 port1 payload", {iss1_vld, iss1_op, iss1_dst}, {1'b1, 16'h2004, 5'd7});
        @(negedge clk);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        #(20 * 150000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule